// File: doc/BRIEF.md
# Decimal Pulse Counter with Sixteen Window Comparators

This block counts pulses on a single asynchronous input in four-digit decimal form (0000 to 9999, wrapping back to 0000). Each input pulse is synchronised, edge-detected and added to the count once. Two paths clear the count. The hard clear is a level input that acts on the next clock edge. The soft clear is a control level that is only sampled on a periodic evaluation tick, so its effect can lag by up to one tick period. While either clear is in force, the count is held at zero and input pulses are discarded.

Next to the counter sits a bank of sixteen lower/upper limit pairs held in 32 local words. These words are loaded through a simple write port. On every clock, the present count is tested against all sixteen inclusive windows in parallel, and the outcome is registered as a 16-bit result word with one bit per window. System logic uses the result word to react when the count enters one of several programmed ranges.

Top module: `window_counter`

## Requirements
- R1: While rst_n is low, count_q is 0000, result_q is 0 and all 32 limit words are 0000.
- R2: A rising edge on cnt_in (held at least two clocks high and two low) adds exactly one to the count. The new count appears on the third rising clock edge that samples cnt_in high.
- R3: count_q holds four BCD digits, with the least significant digit in bits [3:0]. Each digit stays in 0 to 9, and the count wraps from 9999 to 0000.
- R4: At every clock edge where hard_clr is high, count_q becomes 0000, and any pulse due at that edge is discarded.
- R5: soft_clr is captured only at every TICK_DIV-th clock edge after reset release. From the edge after a captured 1, and for as long as the captured value stays 1, count_q is held at 0000 and pulses are discarded.
- R6: The two clears may be active together. Releasing one while the other is still active leaves the count at 0000.
- R7: A write with wr_en high stores wr_data in limit word wr_addr. Word 2n is the lower limit and word 2n+1 is the upper limit of window n. A stored limit is used by the result registered on the following clock edge.
- R8: At each edge, result_q[n] is set to 1 when lower n <= count_q <= upper n, using the count and limits held just before that edge, and to 0 otherwise.
- R9: A window whose lower limit is greater than its upper limit never sets its result bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_in | input | 1 | Asynchronous count pulse input |
| hard_clr | input | 1 | Immediate count clear and pulse block |
| soft_clr | input | 1 | Tick-sampled count clear and pulse block |
| wr_en | input | 1 | Limit word write strobe |
| wr_addr | input | 5 | Limit word address (2n lower, 2n+1 upper) |
| wr_data | input | 16 | Limit value, four BCD digits |
| count_q | output | 16 | Present count, four BCD digits |
| result_q | output | 16 | Window match word, bit n for window n |

## Verification
The bench runs the count through the full 9999 to 0000 rollover. A design with a digit carry bug would show a hex digit or skip the wrap, and one that advanced more than once per pulse would drift from the model. It holds the soft clear across tick boundaries to check that the clear lands only on tick edges, and it overlaps the two clears so that a design letting one release override the other would resume counting too early. It programs an inverted window and rewrites a limit in mid-run. A comparator with swapped operands, an off-by-one at an inclusive bound, or a limit that takes effect a cycle late or early would each produce a result word that differs from the model.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int DIGITS = 4;
  localparam int CW     = 4 * DIGITS;

  typedef logic [CW-1:0] bcd_t;

  // Add one to a packed BCD value, rippling the decimal carry upward.
  function automatic bcd_t bcd_inc(input bcd_t v);
    bcd_t r;
    logic c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (c) begin
        if (r[4*i +: 4] == 4'd9) begin
          r[4*i +: 4] = 4'd0;
        end else begin
          r[4*i +: 4] = r[4*i +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/wc_pulse_sync.sv
module wc_pulse_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [2:0] stage_q;
  logic [2:0] stage_d;

  always_comb begin
    stage_d = {stage_q[1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rise = stage_q[1] & ~stage_q[2];
endmodule

// File: rtl/wc_tick_gate.sv
module wc_tick_gate #(
  parameter int TICK_DIV = 16,
  parameter int TW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  output logic soft_act
);
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          tick;
  logic          soft_d;

  assign tick = (tcnt_q == TW'(TICK_DIV - 1));

  always_comb begin
    tcnt_d = tick ? '0 : tcnt_q + TW'(1);
    soft_d = tick ? soft_clr : soft_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q   <= '0;
      soft_act <= 1'b0;
    end else begin
      tcnt_q   <= tcnt_d;
      soft_act <= soft_d;
    end
  end
endmodule

// File: rtl/wc_bcd_counter.sv
module wc_bcd_counter
  import wc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hard_clr,
  input  logic soft_act,
  input  logic rise,
  output bcd_t count_q
);
  bcd_t count_d;

  always_comb begin
    count_d = count_q;
    if (hard_clr || soft_act) count_d = '0;
    else if (rise)            count_d = bcd_inc(count_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/wc_limit_bank.sv
module wc_limit_bank
  import wc_pkg::*;
#(
  parameter int NWIN = 16,
  parameter int AW   = $clog2(2 * NWIN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  bcd_t                   wr_data,
  input  bcd_t                   count_q,
  output logic [NWIN-1:0]        result_q,
  output logic [2*NWIN*CW-1:0]   lim_flat
);
  localparam int NWORD = 2 * NWIN;

  logic [NWIN-1:0] result_d;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    bcd_t word_q, word_d;
    logic we;

    assign we = wr_en && (wr_addr == AW'(w));

    always_comb begin
      word_d = we ? wr_data : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign lim_flat[w*CW +: CW] = word_q;
  end

  for (genvar n = 0; n < NWIN; n++) begin : g_win
    bcd_t lo, hi;
    assign lo = lim_flat[(2*n)*CW +: CW];
    assign hi = lim_flat[(2*n+1)*CW +: CW];
    // Valid BCD orders the same way as unsigned binary.
    assign result_d[n] = (lo <= count_q) && (count_q <= hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= result_d;
  end
endmodule

// File: rtl/window_counter.sv
module window_counter
  import wc_pkg::*;
#(
  parameter int NWIN     = 16,
  parameter int TICK_DIV = 16,
  parameter int AW       = $clog2(2 * NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_in,
  input  logic            hard_clr,
  input  logic            soft_clr,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  output logic [CW-1:0]   count_q,
  output logic [NWIN-1:0] result_q
);
  logic                 rise;
  logic                 soft_act;
  logic [2*NWIN*CW-1:0] lim_flat;

  wc_pulse_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cnt_in),
    .rise (rise)
  );

  wc_tick_gate #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_clr(soft_clr),
    .soft_act(soft_act)
  );

  wc_bcd_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hard_clr(hard_clr),
    .soft_act(soft_act),
    .rise    (rise),
    .count_q (count_q)
  );

  wc_limit_bank #(.NWIN(NWIN), .AW(AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count_q (count_q),
    .result_q(result_q),
    .lim_flat(lim_flat)
  );
endmodule

// File: rtl/wc_checker.sv
module wc_checker
  import wc_pkg::*;
#(
  parameter int NWIN = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hard_clr,
  input logic                 soft_act,
  input logic [CW-1:0]        count_q,
  input logic [NWIN-1:0]      result_q,
  input logic [2*NWIN*CW-1:0] lim_flat
);
  // R3
  bcd_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q[3:0] <= 4'd9) && (count_q[7:4] <= 4'd9) &&
    (count_q[11:8] <= 4'd9) && (count_q[15:12] <= 4'd9));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |->
      ((count_q == '0) || (count_q == bcd_inc($past(count_q)))));

  // R4
  hard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_clr |=> (count_q == '0));

  // R5
  soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_act |=> (count_q == '0));

  for (genvar n = 0; n < NWIN; n++) begin : g_empty
    // R9
    empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_flat[(2*n)*CW +: CW] > lim_flat[(2*n+1)*CW +: CW]) |=> !result_q[n]);
  end
endmodule

bind window_counter wc_checker #(.NWIN(NWIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hard_clr(hard_clr),
  .soft_act(soft_act),
  .count_q (count_q),
  .result_q(result_q),
  .lim_flat(lim_flat)
);

// File: tb/sim_window_counter.sv
`timescale 1ns/1ps
module sim_window_counter;
  localparam int NWIN = 16;
  localparam int TDIV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_in = 1'b0;
  logic        hard_clr = 1'b0;
  logic        soft_clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_q;
  logic [15:0] result_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  window_counter #(.NWIN(NWIN), .TICK_DIV(TDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .hard_clr(hard_clr),
    .soft_clr(soft_clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_q(count_q), .result_q(result_q)
  );

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(input logic [15:0] b);
    return b[15:12] * 1000 + b[11:8] * 100 + b[7:4] * 10 + b[3:0];
  endfunction

  // Behavioural reference model
  int          m_cnt;
  bit          m_soft;
  int          m_edges;
  bit          m_hist[$];
  logic [15:0] m_lim[2*NWIN];
  logic [15:0] m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_soft = 0; m_edges = 0; m_res = '0;
      m_hist = '{0, 0, 0};
      for (int i = 0; i < 2*NWIN; i++) m_lim[i] = '0;
    end else begin
      bit pulse_due;
      logic [15:0] nres;
      m_edges++;
      // input seen two and three edges back: a 0 then a 1 marks a pulse
      pulse_due = m_hist[1] && !m_hist[2];
      for (int n = 0; n < NWIN; n++)
        nres[n] = (from_bcd(m_lim[2*n]) <= m_cnt) && (m_cnt <= from_bcd(m_lim[2*n+1]));
      m_res = nres;
      if (hard_clr || m_soft) m_cnt = 0;
      else if (pulse_due)     m_cnt = (m_cnt + 1) % 10000;
      if (m_edges % TDIV == 0) m_soft = soft_clr;
      if (wr_en) m_lim[wr_addr] = wr_data;
      m_hist.push_front(cnt_in);
      void'(m_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (count_q !== to_bcd(m_cnt)) begin
        fails++;
        $display("FAIL R1/R2/R3/R4/R5/R6 count act=%h exp=%h t=%0t", count_q, to_bcd(m_cnt), $time);
      end
      checks++;
      if (result_q !== m_res) begin
        fails++;
        $display("FAIL R7/R8/R9 result act=%h exp=%h t=%0t", result_q, m_res, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_in = 1'b1; idle(2);
      cnt_in = 1'b0; idle(2);
    end
  endtask

  task automatic wr(input int a, input int v);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = to_bcd(v);
    idle(1);
    wr_en = 1'b0;
  endtask

  initial begin
    idle(3);
    chk(count_q == 16'h0000, "R1 reset count", count_q, 0);
    chk(result_q == 16'h0000, "R1 reset result", result_q, 0);
    rst_n = 1'b1;
    idle(1);
    // R1: limits reset to 0000, so every window holds the zero count
    idle(1);
    chk(result_q == 16'hFFFF, "R1 zero limits match count 0", result_q, 16'hFFFF);

    // R7 program windows
    wr(0, 0);  wr(1, 5);
    wr(2, 3);  wr(3, 3);
    wr(4, 10); wr(5, 20);
    wr(6, 50); wr(7, 40);
    for (int n = 4; n < 15; n++) begin
      wr(2*n, 5*n); wr(2*n+1, 5*n+7);
    end
    wr(30, 0); wr(31, 9999);
    idle(2);

    pulse(3);
    chk(count_q == 16'h0003, "R2 three pulses", count_q, 3);
    chk(result_q[1] && result_q[0], "R8 inclusive window [3,3]", result_q, 3);
    pulse(42);
    chk(count_q == 16'h0045, "R2 forty-five pulses", count_q, 16'h45);
    chk(!result_q[3], "R9 inverted window stays 0", result_q[3], 0);
    chk(!result_q[2] && result_q[15], "R8 outside/inside windows", result_q, 0);

    hard_clr = 1'b1;
    pulse(3);
    chk(count_q == 16'h0000, "R4 hard clear blocks pulses", count_q, 0);
    hard_clr = 1'b0;
    idle(1);
    pulse(7);
    chk(count_q == 16'h0007, "R4 count resumes after hard clear", count_q, 7);

    chk(!result_q[4], "R7 window 4 before write", result_q[4], 0);
    wr(8, 7);
    idle(1);
    chk(result_q[4], "R7 window 4 after lower write", result_q[4], 1);

    soft_clr = 1'b1;
    pulse(10);
    chk(count_q == 16'h0000, "R5 soft clear holds zero", count_q, 0);
    soft_clr = 1'b0;
    idle(2 * TDIV);
    pulse(2);
    chk(count_q == 16'h0002, "R5 count resumes after soft clear", count_q, 2);

    soft_clr = 1'b1; hard_clr = 1'b1;
    pulse(9);
    chk(count_q == 16'h0000, "R6 both clears", count_q, 0);
    hard_clr = 1'b0;
    pulse(3);
    chk(count_q == 16'h0000, "R6 soft still holds after hard release", count_q, 0);
    soft_clr = 1'b0;
    idle(2 * TDIV);
    pulse(1);
    chk(count_q == 16'h0001, "R6 resume after both released", count_q, 1);

    hard_clr = 1'b1; idle(1); hard_clr = 1'b0; idle(2);
    pulse(9999);
    chk(count_q == 16'h9999, "R3 count reaches 9999", count_q, 16'h9999);
    pulse(1);
    chk(count_q == 16'h0000, "R3 wrap to 0000", count_q, 0);
    chk(result_q[15] && result_q[0], "R8 windows after wrap", result_q, 16'h8001);

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule